// File: doc/BRIEF.md
# Four-Channel Paddle Position Digitizer

The block converts the settings of four resistive paddles (X0, Y0, X1, Y1) into 8-bit numbers. It times how long an external resistor and capacitor take to charge. A register write with bit 0 set starts a conversion. That write clears one shared counter, and every pad that is not a general-purpose output is pulled low for a fixed number of ticks, which empties its capacitor. The pads are then released and the counter counts upward at a programmable tick rate until it saturates. While a pad still senses low, its channel copies the counter value. Once the pad senses high, the copied value freezes, so the result grows with the paddle's resistance.

Any pad can instead act as a plain output under control-word bits. The filtered level of every pad is readable on a status word. Results are always readable as two 16-bit words, each holding one X/Y pair. The pads are modelled as a tri-state driver (`pad_oe`, `pad_out`) plus a digital input `pad_in`. The input passes through a two-flop synchroniser and a hysteresis filter.

Top module: `paddle_digitizer`

## Requirements
- R1: After synchronous reset all result bytes are 0, no pad is driven (`pad_oe` = 0, `pad_out` = 0), every sensed level is 1, and `status` reads 16'h5500.
- R2: Channel index 0..3 is X0, Y0, X1, Y1. `result0` = {Y0, X0} and `result1` = {Y1, X1}, with X in bits 7:0 and Y in bits 15:8.
- R3: A write with `ctrl_wdata[0]`=1 clears the counter on that clock edge. For the next DISCH_TICKS*(tick_div+1) cycles, `pad_oe` is 1 on every channel.
- R4: After the discharge phase the counter rises by exactly one every tick_div+1 clocks. Taking the start write as edge s, the counter after edge n equals min(max((n-s)/(tick_div+1) - DISCH_TICKS, 0), 255).
- R5: A result byte takes the counter value of the previous cycle whenever its sensed level was 0, and holds its value whenever the sensed level was 1.
- R6: On each write, control bit 9+2i enables channel i as an output and bit 8+2i gives its level. `pad_out[i]` = enable AND level, and `pad_oe[i]` = 1 whenever the enable is set.
- R7: `status` bit 8+2i is the sensed level of channel i, and all other status bits are 0. The sensed level goes to 1 (or to 0) only when the raw pad values sampled at edges n-2 through n-1-FILT_LEN were all 1 (or all 0). Otherwise it holds.
- R8: The counter saturates at 255 and never wraps. A pad held low for a whole conversion reads 255.
- R9: A start write during a running conversion restarts it immediately: the counter goes to 0 and a new discharge phase begins.
- R10: A write with bit 0 = 0 updates only the pad output controls. It neither starts a discharge nor disturbs the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: bit 0 start, bits 8..15 pad output level/enable pairs |
| tick_div | input | DIV_W | Counter advances every tick_div+1 clocks |
| pad_in | input | 4 | Raw digital pad levels, channels X0, Y0, X1, Y1 |
| pad_oe | output | 4 | Pad driver enables |
| pad_out | output | 4 | Pad driver levels |
| result0 | output | 2*CNT_W | {Y0, X0} results |
| result1 | output | 2*CNT_W | {Y1, X1} results |
| status | output | 16 | Sensed pad levels at bits 8, 10, 12, 14 |

## Verification
The bench targets several timing and state corner cases:
- The exact length of the discharge window. An off-by-one tick count shows up as a one-cycle mismatch on `pad_oe`.
- Saturation with a pad that never charges. A design that wraps would make the result fall back toward 0.
- A restart issued while counting. A design that ignores it keeps the old count in the stuck-low channel instead of dropping to 0 one cycle later.
- A control-only write. A design that treats every write as a start would re-drive all pads low.

A behavioural model predicts the filter latency from the pad history. Any extra or missing register stage in the synchroniser, filter or capture path therefore appears as a shifted result.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {PD_IDLE, PD_DISCH, PD_COUNT} pd_state_e;
endpackage

// File: rtl/pd_prescaler.sv
module pd_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] presc_q;

  assign tick = run && (presc_q == div);

  always_ff @(posedge clk) begin
    if (rst || clear) presc_q <= '0;
    else if (run)     presc_q <= (presc_q == div) ? '0 : presc_q + 1'b1;
  end
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer import pd_pkg::*; #(
  parameter int CNT_W       = 8,
  parameter int DISCH_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  output pd_state_e        state,
  output logic [CNT_W-1:0] count
);
  localparam int DC_W = (DISCH_TICKS > 1) ? $clog2(DISCH_TICKS) : 1;
  localparam logic [DC_W-1:0]  DC_LAST = DC_W'(DISCH_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DC_W-1:0] dcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PD_IDLE;
      dcnt_q <= '0;
      count  <= '0;
    end else if (start) begin
      state  <= PD_DISCH;
      dcnt_q <= '0;
      count  <= '0;
    end else if (tick) begin
      case (state)
        PD_DISCH: begin
          dcnt_q <= dcnt_q + 1'b1;
          if (dcnt_q == DC_LAST) state <= PD_COUNT;
        end
        PD_COUNT: if (count != CNT_MAX) count <= count + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pd_pad_filter.sv
module pd_pad_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_raw,
  output logic level
);
  localparam int HW = (FILT_LEN > 1) ? FILT_LEN - 1 : 1;

  logic          s1_q, s2_q;
  logic [HW-1:0] hist_q;
  logic [HW:0]   window;

  assign window = {hist_q, s2_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      hist_q <= '1;
      level  <= 1'b1;
    end else begin
      s1_q   <= pad_raw;
      s2_q   <= s1_q;
      hist_q <= HW'(window);
      if (&window[FILT_LEN-1:0])       level <= 1'b1;
      else if (~|window[FILT_LEN-1:0]) level <= 1'b0;
    end
  end
endmodule

// File: rtl/paddle_digitizer.sv
module paddle_digitizer import pd_pkg::*; #(
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 16,
  parameter int DISCH_TICKS = 8,
  parameter int FILT_LEN    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  logic [15:0]        ctrl_wdata,
  input  logic [DIV_W-1:0]   tick_div,
  input  logic [3:0]         pad_in,
  output logic [3:0]         pad_oe,
  output logic [3:0]         pad_out,
  output logic [2*CNT_W-1:0] result0,
  output logic [2*CNT_W-1:0] result1,
  output logic [15:0]        status
);
  localparam int NCH = 4;

  logic             start, tick, run, disch;
  logic [NCH-1:0]   oe_q, lvl_q, level;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] res_q [NCH];
  pd_state_e        seq_state;
  logic             unused_wbits;

  assign start        = ctrl_we & ctrl_wdata[0];
  assign unused_wbits = ^ctrl_wdata[7:1];
  assign run          = (seq_state != PD_IDLE);
  assign disch        = (seq_state == PD_DISCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      lvl_q <= '0;
    end else if (ctrl_we) begin
      for (int i = 0; i < NCH; i++) begin
        oe_q[i]  <= ctrl_wdata[9 + 2*i];
        lvl_q[i] <= ctrl_wdata[8 + 2*i];
      end
    end
  end

  pd_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .clear(start), .run(run), .div(tick_div), .tick(tick)
  );

  pd_sequencer #(.CNT_W(CNT_W), .DISCH_TICKS(DISCH_TICKS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .state(seq_state), .count(count)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pd_pad_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst(rst), .pad_raw(pad_in[ch]), .level(level[ch])
    );
    always_ff @(posedge clk) begin
      if (rst)             res_q[ch] <= '0;
      else if (!level[ch]) res_q[ch] <= count;
    end
  end

  assign pad_oe  = oe_q | {NCH{disch}};
  assign pad_out = oe_q & lvl_q;
  assign result0 = {res_q[1], res_q[0]};
  assign result1 = {res_q[3], res_q[2]};

  always_comb begin
    status = '0;
    for (int i = 0; i < NCH; i++) status[8 + 2*i] = level[i];
  end
endmodule

// File: rtl/paddle_digitizer_chk.sv
module paddle_digitizer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             disch,
  input logic [CNT_W-1:0] count,
  input logic             lvl_x0,
  input logic [CNT_W-1:0] res_x0,
  input logic [3:0]       pad_oe
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> count == '0);

  p_disch_drive_r3: assert property (@(posedge clk) disable iff (rst)
    disch |-> pad_oe == 4'hF);

  p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    !start |=> (count == $past(count) || count == $past(count) + 1'b1));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && !start) |=> count == CMAX);

  p_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !lvl_x0 |=> res_x0 == $past(count));

  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    lvl_x0 |=> $stable(res_x0));
endmodule

bind paddle_digitizer paddle_digitizer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .disch(disch), .count(count),
  .lvl_x0(level[0]), .res_x0(res_q[0]), .pad_oe(pad_oe)
);

// File: tb/test_paddle_digitizer.sv
module test_paddle_digitizer;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 8;
  localparam int FL         = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] tick_div = 16'd2;
  logic [3:0]  pad_in = 4'hF;
  logic [3:0]  pad_oe, pad_out;
  logic [15:0] result0, result1, status;

  int checks = 0, failures = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paddle_digitizer i_paddle_digitizer (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tick_div(tick_div), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .result0(result0), .result1(result1), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int         cyc = 0, s_edge = 0, per = 1;
  bit         started = 1'b0;
  logic [3:0] m_oe_c = '0, m_lvl_c = '0, m_lvl = 4'hF;
  logic [7:0] m_res [4];
  int         m_cnt = 0;
  logic [3:0] padq [$];

  function automatic int cnt_at(int n);
    int c;
    c = (n - s_edge) / per - D;
    if (c < 0) c = 0;
    if (c > 255) c = 255;
    return c;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      started = 1'b0; m_oe_c = '0; m_lvl_c = '0; m_lvl = 4'hF; m_cnt = 0;
      for (int i = 0; i < 4; i++) m_res[i] = '0;
      padq.delete();
      for (int i = 0; i < FL + 2; i++) padq.push_front(4'hF);
    end else begin
      logic [3:0] nl;
      padq.push_front(pad_in);
      void'(padq.pop_back());
      for (int i = 0; i < 4; i++) begin
        int ones;
        ones = 0;
        for (int k = 2; k <= FL + 1; k++) ones += padq[k][i];
        nl[i] = (ones == FL) ? 1'b1 : (ones == 0) ? 1'b0 : m_lvl[i];
        if (!m_lvl[i]) m_res[i] = m_cnt[7:0];
      end
      m_lvl = nl;
      if (ctrl_we) begin
        for (int i = 0; i < 4; i++) begin
          m_oe_c[i]  = ctrl_wdata[9 + 2*i];
          m_lvl_c[i] = ctrl_wdata[8 + 2*i];
        end
      end
      if (ctrl_we && ctrl_wdata[0]) begin
        started = 1'b1; s_edge = cyc; per = int'(tick_div) + 1;
      end
      m_cnt = started ? cnt_at(cyc) : 0;
    end
  end

  // per-cycle comparison and RC pad emulation
  int rel [4] = '{0, 0, 0, 0};
  int thr [4] = '{20, 60, 150, 1000000};

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [3:0]  eoe;
      logic [15:0] est;
      eoe = m_oe_c | ((started && cyc < s_edge + D*per) ? 4'hF : 4'h0);
      est = '0;
      for (int i = 0; i < 4; i++) est[8 + 2*i] = m_lvl[i];
      chk(result0 == {m_res[1], m_res[0]}, "R5 result0", result0, {m_res[1], m_res[0]});
      chk(result1 == {m_res[3], m_res[2]}, "R5 result1", result1, {m_res[3], m_res[2]});
      chk(pad_oe == eoe, "R3 pad_oe", pad_oe, eoe);
      chk(pad_out == (m_oe_c & m_lvl_c), "R6 pad_out", pad_out, m_oe_c & m_lvl_c);
      chk(status == est, "R7 status", status, est);
    end
    for (int i = 0; i < 4; i++) begin
      if (pad_oe[i]) rel[i] = 0; else if (rel[i] < 2000000) rel[i]++;
      pad_in[i] = pad_oe[i] ? pad_out[i] : (rel[i] >= thr[i]);
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(result0 == 16'h0 && result1 == 16'h0, "R1 results", {result1, result0}, 0);
    chk(pad_oe == 4'h0 && pad_out == 4'h0, "R1 pads", {pad_oe, pad_out}, 0);
    chk(status == 16'h5500, "R1 status", status, 16'h5500);
    cmp_en = 1'b1;

    // first conversion, tick_div=2
    wr(16'h0001);
    repeat (1200) @(negedge clk);
    chk(result1[15:8] == 8'd255, "R8 saturation Y1", result1[15:8], 255);
    chk(result0[7:0] != 0 && result0[7:0] < result0[15:8], "R2 X0<Y0 ordering",
        result0, 0);
    chk(result1[7:0] > result0[15:8], "R2 X1 above Y0", result1[7:0], result0[15:8]);

    // restart during a conversion
    wr(16'h0001);
    repeat (100) @(negedge clk);
    chk(result1[15:8] != 0, "R9 count before restart", result1[15:8], 1);
    wr(16'h0001);
    @(negedge clk);
    chk(result1[15:8] == 0, "R9 restart clears", result1[15:8], 0);
    chk(pad_oe == 4'hF, "R9 new discharge", pad_oe, 4'hF);
    repeat (1100) @(negedge clk);

    // fastest tick rate
    tick_div = 16'd0;
    wr(16'h0001);
    repeat (400) @(negedge clk);
    chk(result1[15:8] == 8'd255, "R4 fast rate saturates", result1[15:8], 255);

    // pads as outputs, no start
    wr(16'h0B00);
    repeat (10) @(negedge clk);
    chk(pad_oe[1:0] == 2'b11 && pad_out[1:0] == 2'b01, "R6 gpio drive",
        {pad_oe, pad_out}, 8'h31);
    chk(pad_oe[3:2] == 2'b00, "R10 no discharge on control write", pad_oe, 4'h3);
    chk(status[8] == 1'b1 && status[10] == 1'b0, "R7 level readback", status, 16'h0100);
    chk(result0[15:8] == 8'd255, "R5 low pad captures count", result0[15:8], 255);
    wr(16'h0100);
    repeat (10) @(negedge clk);
    chk(pad_oe == 4'h0 && pad_out == 4'h0, "R10 release only", {pad_oe, pad_out}, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule